// File: doc/BRIEF.md
# Partitioned Ping-Pong Transfer Buffer

This block is a 4 KB on-chip transfer RAM that is shared by two clients: the host processor and a USB transfer engine. The RAM is split into two areas at run time. A flat area holds the data of acknowledged transfers (control, bulk and interrupt). A second area holds the data of isochronous transfers and is cut into two equal banks that work as a ping-pong pair. At any moment one isochronous bank belongs to the processor and the other belongs to the engine, so both can work on isochronous data in the same cycle. A swap strobe exchanges the two banks.

Both clients address the RAM by region and byte offset. The block turns that into a physical word address. The first isochronous bank starts at byte 0. The second bank starts right after it, at the isochronous length. The flat area starts at twice the isochronous length. Two length registers are reached through an 8-bit command port. A new split is accepted only if the flat length plus twice the isochronous length fits inside the RAM. Accesses that fall outside their region are blocked and flagged.

Top module: `pingpong_xfer_buf`

## Requirements
- R1: After reset, the flat length is 800H, the isochronous bank length is 400H, `cpu_bank` is 0 (the processor owns bank 0 and the engine owns bank 1), and `cfg_err` is 0.
- R2: On a `cfg_valid` cycle, `cfg_cmd[7]`=1 means write and 0 means read. Bits [6:0] select the register: 2BH for the flat length and 2AH for the isochronous length. A read puts the length on `cfg_rdata` in the next cycle, and any other code reads 0. A written length has bit 0 cleared. A write to any other code changes nothing.
- R3: A length write is accepted only if the new flat length plus twice the new isochronous length is 1000H or less. If it is not, both lengths keep their old values and `cfg_err` is set. `cfg_err` stays set until reset.
- R4: Physical byte addresses are as follows. Bank 0 offset `o` maps to `o`. Bank 1 offset `o` maps to ITL+`o`. Flat offset `o` maps to 2×ITL+`o`. Each word holds 16 bits, so offset bit 0 is ignored. `*_region` is 1 for the isochronous area and 0 for the flat area.
- R5: An isochronous access from the processor uses bank `cpu_bank`. An isochronous access from the engine uses the other bank.
- R6: A `bank_swap` pulse toggles `cpu_bank` at the clock edge. Accesses made in the same cycle as the swap still use the old ownership.
- R7: An access is out of range when its offset is equal to or greater than its region's length. An out-of-range read returns 0. An out-of-range write leaves the RAM unchanged. `*_oor` is 1 for exactly the cycle after an out-of-range access.
- R8: A read (`*_en`=1, `*_we`=0) shows its data on `*_rdata` one cycle later. A read returns the word as it was before any write made in the same cycle.
- R9: If both ports write the same word in the same cycle, the processor's data is the value that is kept.
- R10: A length change is used by all address mapping and range checks from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Command strobe |
| cfg_cmd | input | 8 | Command code: bit 7 selects write, bits [6:0] select the register |
| cfg_wdata | input | 13 | Length to write, in bytes |
| cfg_rdata | output | 13 | Length read back, one cycle after the command |
| cfg_err | output | 1 | Sticky flag for a rejected length write |
| bank_swap | input | 1 | Strobe that swaps isochronous bank ownership |
| cpu_bank | output | 1 | Isochronous bank currently owned by the processor |
| cpu_en | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor write enable |
| cpu_region | input | 1 | Processor region: 1 = isochronous, 0 = flat |
| cpu_off | input | 12 | Processor byte offset within the region |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data |
| cpu_oor | output | 1 | Processor out-of-range pulse |
| eng_en | input | 1 | Engine access strobe |
| eng_we | input | 1 | Engine write enable |
| eng_region | input | 1 | Engine region: 1 = isochronous, 0 = flat |
| eng_off | input | 12 | Engine byte offset within the region |
| eng_wdata | input | 16 | Engine write data |
| eng_rdata | output | 16 | Engine read data |
| eng_oor | output | 1 | Engine out-of-range pulse |

## Verification
Two pairs of events can land in the same cycle: a bank swap with a data access, and a length write with a data access. In both cases the access must still use the ownership and the lengths that held before the edge. Directed steps set these up. One step writes isochronous data with `bank_swap` high and then reads the same word back through the engine. Another step reprograms a length while both ports are busy. A bench model that updates its state only after it has worked out the outputs for the cycle decides whether each result is correct. Random traffic then raises swaps, illegal writes and accesses at the region edges together, many times over.

// File: rtl/pingpong_xfer_buf.sv
module pingpong_xfer_buf #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int ATL_INIT = 'h800,
  parameter int ITL_INIT = 'h400,
  parameter logic [6:0] CODE_ATL = 7'h2B,
  parameter logic [6:0] CODE_ITL = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [7:0]        cfg_cmd,
  input  logic [ADDR_W:0]   cfg_wdata,
  output logic [ADDR_W:0]   cfg_rdata,
  output logic              cfg_err,
  input  logic              bank_swap,
  output logic              cpu_bank,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic              cpu_region,
  input  logic [ADDR_W-1:0] cpu_off,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_oor,
  input  logic              eng_en,
  input  logic              eng_we,
  input  logic              eng_region,
  input  logic [ADDR_W-1:0] eng_off,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] eng_rdata,
  output logic              eng_oor
);
  localparam int LEN_W = ADDR_W + 1;
  localparam int BPW   = DATA_W / 8;
  localparam int WSH   = $clog2(BPW);
  localparam int WORDS = (1 << ADDR_W) / BPW;
  localparam int WA_W  = ADDR_W - WSH;
  localparam int LIMIT = 1 << ADDR_W;

  logic [LEN_W-1:0]  atl_len, itl_len;
  logic [DATA_W-1:0] mem [WORDS];

  // configuration command decode and size check
  logic [6:0]       code;
  logic             cfg_wr, wr_atl, wr_itl;
  logic [LEN_W-1:0] wlen, n_atl, n_itl;
  logic [LEN_W+1:0] n_sum;
  logic             n_legal;

  assign code    = cfg_cmd[6:0];
  assign cfg_wr  = cfg_valid & cfg_cmd[7];
  assign wr_atl  = cfg_wr && (code == CODE_ATL);
  assign wr_itl  = cfg_wr && (code == CODE_ITL);
  assign wlen    = cfg_wdata & ~LEN_W'(BPW - 1);
  assign n_atl   = wr_atl ? wlen : atl_len;
  assign n_itl   = wr_itl ? wlen : itl_len;
  assign n_sum   = {2'b00, n_atl} + {1'b0, n_itl, 1'b0};
  assign n_legal = n_sum <= (LEN_W+2)'(LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      atl_len   <= LEN_W'(ATL_INIT);
      itl_len   <= LEN_W'(ITL_INIT);
      cfg_err   <= 1'b0;
      cfg_rdata <= '0;
    end else if (cfg_valid) begin
      if (cfg_wr) begin
        if (wr_atl || wr_itl) begin
          if (n_legal) begin
            atl_len <= n_atl;
            itl_len <= n_itl;
          end else begin
            cfg_err <= 1'b1;
          end
        end
      end else begin
        cfg_rdata <= (code == CODE_ATL) ? atl_len :
                     (code == CODE_ITL) ? itl_len : '0;
      end
    end
  end

  // bank ownership
  always_ff @(posedge clk) begin
    if (!rst_n) cpu_bank <= 1'b0;
    else if (bank_swap) cpu_bank <= ~cpu_bank;
  end

  // address mapping, one set per port
  logic [LEN_W-1:0] atl_base;
  assign atl_base = LEN_W'({itl_len, 1'b0});

  logic [LEN_W-1:0] c_base, c_lim, c_phys;
  logic [WA_W-1:0]  c_wa;
  logic             c_in, c_wr, c_rd;
  assign c_base = cpu_region ? (cpu_bank ? itl_len : '0) : atl_base;
  assign c_lim  = cpu_region ? itl_len : atl_len;
  assign c_in   = {1'b0, cpu_off} < c_lim;
  assign c_phys = c_base + {1'b0, cpu_off};
  assign c_wa   = WA_W'(c_phys >> WSH);
  assign c_wr   = cpu_en & cpu_we & c_in;
  assign c_rd   = cpu_en & ~cpu_we;

  logic [LEN_W-1:0] e_base, e_lim, e_phys;
  logic [WA_W-1:0]  e_wa;
  logic             e_in, e_wr, e_rd;
  assign e_base = eng_region ? (cpu_bank ? '0 : itl_len) : atl_base;
  assign e_lim  = eng_region ? itl_len : atl_len;
  assign e_in   = {1'b0, eng_off} < e_lim;
  assign e_phys = e_base + {1'b0, eng_off};
  assign e_wa   = WA_W'(e_phys >> WSH);
  assign e_wr   = eng_en & eng_we & e_in;
  assign e_rd   = eng_en & ~eng_we;

  // storage: processor write placed last so it wins a collision
  always_ff @(posedge clk) begin
    if (e_wr) mem[e_wa] <= eng_wdata;
    if (c_wr) mem[c_wa] <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      eng_rdata <= '0;
      cpu_oor   <= 1'b0;
      eng_oor   <= 1'b0;
    end else begin
      cpu_oor <= cpu_en & ~c_in;
      eng_oor <= eng_en & ~e_in;
      if (c_rd) cpu_rdata <= c_in ? mem[c_wa] : '0;
      if (e_rd) eng_rdata <= e_in ? mem[e_wa] : '0;
    end
  end

  a_r3_split_fits: assert property (@(posedge clk) disable iff (!rst_n)
    ({2'b00, atl_len} + {1'b0, itl_len, 1'b0}) <= (LEN_W+2)'(LIMIT));

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r6_swap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    bank_swap |=> (cpu_bank != $past(cpu_bank)));

  a_r6_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_swap |=> $stable(cpu_bank));

  a_r7_cpu_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && !cpu_we && !c_in) |=> (cpu_oor && cpu_rdata == '0));

  a_r7_eng_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en && !eng_we && !e_in) |=> (eng_oor && eng_rdata == '0));

  a_r3_bad_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_cmd[7] && !n_legal) |=> ($stable(atl_len) && $stable(itl_len)));
endmodule

// File: tb/test_pingpong_xfer_buf.sv
module test_pingpong_xfer_buf;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cfg_valid;
  logic [7:0]  cfg_cmd;
  logic [12:0] cfg_wdata, cfg_rdata;
  logic        cfg_err, bank_swap, cpu_bank;
  logic        cpu_en, cpu_we, cpu_region, cpu_oor;
  logic [11:0] cpu_off;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        eng_en, eng_we, eng_region, eng_oor;
  logic [11:0] eng_off;
  logic [15:0] eng_wdata, eng_rdata;

  pingpong_xfer_buf i_pingpong_xfer_buf (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .bank_swap(bank_swap), .cpu_bank(cpu_bank),
    .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_region(cpu_region), .cpu_off(cpu_off),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_oor(cpu_oor),
    .eng_en(eng_en), .eng_we(eng_we), .eng_region(eng_region), .eng_off(eng_off),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_oor(eng_oor)
  );

  int unsigned n_chk = 0, n_bad = 0;
  int unsigned m_atl, m_itl;
  bit          m_bank, m_err;
  int unsigned m_mem [2048];

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned lim_of(bit region);
    return region ? m_itl : m_atl;
  endfunction

  function automatic int unsigned word_of(bit region, bit bank, int unsigned off);
    int unsigned base;
    base = region ? (bank ? m_itl : 0) : 2 * m_itl;
    return ((base + off) >> 1) & 'h7FF;
  endfunction

  task automatic idle();
    cfg_valid = 0; cfg_cmd = 0; cfg_wdata = 0; bank_swap = 0;
    cpu_en = 0; cpu_we = 0; cpu_region = 0; cpu_off = 0; cpu_wdata = 0;
    eng_en = 0; eng_we = 0; eng_region = 0; eng_off = 0; eng_wdata = 0;
  endtask

  // one clock: model computes outputs from pre-edge state, then updates
  task automatic step();
    bit c_in, e_in, c_rd, e_rd, cfg_rd;
    int unsigned c_w, e_w, exp_c, exp_e, exp_cfg;
    c_in = cpu_off < lim_of(cpu_region);
    e_in = eng_off < lim_of(eng_region);
    c_w  = word_of(cpu_region, m_bank, cpu_off);
    e_w  = word_of(eng_region, !m_bank, eng_off);
    c_rd = cpu_en && !cpu_we;
    e_rd = eng_en && !eng_we;
    exp_c = c_in ? m_mem[c_w] : 0;
    exp_e = e_in ? m_mem[e_w] : 0;
    cfg_rd = cfg_valid && !cfg_cmd[7];
    exp_cfg = (cfg_cmd[6:0] == 7'h2B) ? m_atl : (cfg_cmd[6:0] == 7'h2A) ? m_itl : 0;
    if (eng_en && eng_we && e_in) m_mem[e_w] = eng_wdata;
    if (cpu_en && cpu_we && c_in) m_mem[c_w] = cpu_wdata;
    if (bank_swap) m_bank = !m_bank;
    if (cfg_valid && cfg_cmd[7] && (cfg_cmd[6:0] == 7'h2B || cfg_cmd[6:0] == 7'h2A)) begin
      int unsigned na, ni;
      na = (cfg_cmd[6:0] == 7'h2B) ? (cfg_wdata & 'h1FFE) : m_atl;
      ni = (cfg_cmd[6:0] == 7'h2A) ? (cfg_wdata & 'h1FFE) : m_itl;
      if (na + 2 * ni <= 'h1000) begin m_atl = na; m_itl = ni; end
      else m_err = 1;
    end
    @(posedge clk); #1;
    if (c_rd) chk("R4/R5/R8 cpu_rdata", cpu_rdata, exp_c);
    if (e_rd) chk("R4/R5/R8 eng_rdata", eng_rdata, exp_e);
    chk("R7 cpu_oor", cpu_oor, cpu_en && !c_in);
    chk("R7 eng_oor", eng_oor, eng_en && !e_in);
    if (cfg_rd) chk("R2 cfg_rdata", cfg_rdata, exp_cfg);
    chk("R3 cfg_err", cfg_err, m_err);
    chk("R6 cpu_bank", cpu_bank, m_bank);
    @(negedge clk);
    idle();
  endtask

  task automatic cfg_op(bit wr, logic [6:0] code, int unsigned val);
    cfg_valid = 1; cfg_cmd = {wr, code}; cfg_wdata = 13'(val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    rst_n = 0;
    m_atl = 'h800; m_itl = 'h400; m_bank = 0; m_err = 0;
    foreach (m_mem[i]) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cpu_bank", cpu_bank, 0);
    chk("R1 cfg_err", cfg_err, 0);
    rst_n = 1;
    cfg_op(0, 7'h2B, 0); step();   // R1 flat length 800H
    cfg_op(0, 7'h2A, 0); step();   // R1 iso length 400H
    cfg_op(0, 7'h11, 0); step();   // R2 unknown code reads 0

    // fill whole RAM: flat via cpu, bank0 via cpu, bank1 via engine (R4, R5)
    for (int o = 0; o < 'h800; o += 2) begin
      cpu_en = 1; cpu_we = 1; cpu_region = 0; cpu_off = 12'(o); cpu_wdata = 16'($urandom);
      step();
    end
    for (int o = 0; o < 'h400; o += 2) begin
      cpu_en = 1; cpu_we = 1; cpu_region = 1; cpu_off = 12'(o); cpu_wdata = 16'($urandom);
      eng_en = 1; eng_we = 1; eng_region = 1; eng_off = 12'(o); eng_wdata = 16'($urandom);
      step();
    end
    // R7: out-of-range reads and writes
    cpu_en = 1; cpu_we = 0; cpu_region = 1; cpu_off = 12'h400; step();
    cpu_en = 1; cpu_we = 1; cpu_region = 1; cpu_off = 12'h402; cpu_wdata = 16'hDEAD; step();
    cpu_en = 1; cpu_we = 0; cpu_region = 1; cpu_off = 12'h3FE;
    eng_en = 1; eng_we = 0; eng_region = 0; eng_off = 12'h7FF; step();

    // R3: illegal flat length is rejected, old values kept
    cfg_op(1, 7'h2B, 'h900); step();
    cfg_op(0, 7'h2B, 0); step();
    // R2: odd length has bit 0 cleared; R10 access in same cycle uses old map
    cfg_op(1, 7'h2A, 'h201);
    cpu_en = 1; cpu_we = 0; cpu_region = 0; cpu_off = 12'h10;
    eng_en = 1; eng_we = 0; eng_region = 1; eng_off = 12'h300; step();
    cfg_op(0, 7'h2A, 0);
    cpu_en = 1; cpu_we = 0; cpu_region = 0; cpu_off = 12'h10;
    eng_en = 1; eng_we = 0; eng_region = 1; eng_off = 12'h300; step();
    cfg_op(1, 7'h2A, 'h400); step();
    cfg_op(1, 7'h15, 'h0); step();   // R2 write to other code ignored
    cfg_op(0, 7'h2A, 0); step();

    // R6: write with swap in the same cycle lands in the old bank
    cpu_en = 1; cpu_we = 1; cpu_region = 1; cpu_off = 12'h20; cpu_wdata = 16'hA5A5;
    bank_swap = 1; step();
    eng_en = 1; eng_we = 0; eng_region = 1; eng_off = 12'h20; step();
    cpu_en = 1; cpu_we = 0; cpu_region = 1; cpu_off = 12'h20; step();
    bank_swap = 1; step();

    // R9: both ports write the same flat word
    cpu_en = 1; cpu_we = 1; cpu_region = 0; cpu_off = 12'h40; cpu_wdata = 16'h1111;
    eng_en = 1; eng_we = 1; eng_region = 0; eng_off = 12'h41; eng_wdata = 16'h2222; step();
    cpu_en = 1; cpu_we = 0; cpu_region = 0; cpu_off = 12'h40; step();

    // full use of RAM by the flat area alone, then back (R3 legal edge)
    cfg_op(1, 7'h2A, 0); step();
    cfg_op(1, 7'h2B, 'h1000); step();
    cpu_en = 1; cpu_we = 0; cpu_region = 0; cpu_off = 12'hFFE; step();
    cfg_op(1, 7'h2B, 'h800); step();
    cfg_op(1, 7'h2A, 'h400); step();

    // random mixed traffic (R4..R10)
    for (int n = 0; n < 6000; n++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 4) begin
        int unsigned pick;
        pick = $urandom % 6;
        cfg_op(1, ($urandom % 2) ? 7'h2B : 7'h2A,
               (pick == 0) ? 'h900 : (pick == 1) ? 'h401 : 'h100 * ($urandom % 9));
      end else if (r < 8) begin
        cfg_op(0, ($urandom % 2) ? 7'h2B : 7'h2A, 0);
      end
      bank_swap = ($urandom % 10) == 0;
      cpu_en = $urandom % 2; cpu_we = $urandom % 2; cpu_region = $urandom % 2;
      cpu_off = 12'(($urandom % (lim_of(cpu_region) + 'h20)));
      cpu_wdata = 16'($urandom);
      eng_en = $urandom % 2; eng_we = $urandom % 2; eng_region = $urandom % 2;
      eng_off = 12'(($urandom % (lim_of(eng_region) + 'h20)));
      eng_wdata = 16'($urandom);
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule